// File: doc/BRIEF.md
# DDR3 Burst Current Stress Pattern Generator

This block produces the command, address and write-data stimulus used to hold a DDR3 device in a continuous burst-read or burst-write state, as needed when measuring its burst operating current. While running, it issues one column command every fourth clock and fills the three cycles between commands with deselects. Each command goes to the next bank in ascending order, and the column address moves by one BL8 burst on every command. The auto-precharge address bit is never set. With BL8 each command covers four clocks of data, so the bursts follow each other with no gap.

A `run` level starts and stops the stream. The `wr_mode` input picks reads or writes. It is sampled only when a run starts, and later changes are ignored until the next start. In write mode the block also delivers write data at two beats per clock. Every beat is the bitwise inverse of the one before it. A valid flag covers the whole stream, and the data mask is held low. Device initialisation, row activation, the PHY and calibration are handled elsewhere.

Top module: `burst_stress_gen`

## Requirements
- R1: While running, a command is issued on the clock after `run` is first seen high at a rising edge, and then on every fourth clock. The three clocks between two commands are deselects.
- R2: Pin encodings as {cs_n,ras_n,cas_n,we_n}: READ is 0101, WRITE is 0100 and deselect is 1111. Every clock that is not a command slot is a deselect, and so is every clock while the block is idle.
- R3: The first command of every run targets bank 0. Each later command targets the next bank, and the bank after NUM_BANKS-1 is bank 0.
- R4: On a command, `addr[10]` is 0. The column for the n-th command of a run (counting from 0) is (8·n) mod 2^COL_W, placed on `addr[COL_W-1:0]`. Every other address bit is 0. On deselect cycles `addr` and `ba` are 0.
- R5: In write mode, `wvalid` is 1 on every clock of the run, and `wdata` = {~PATTERN, PATTERN`}. The low half is the first beat of the clock and the high half is the second beat, so the data inverts on every beat. In read mode and when idle, `wvalid` is 0 and `wdata` is 0.
- R6: `dm` is 0 on every clock.
- R7: The mode is captured at the start of a run. Changing `wr_mode` during a run has no effect on the commands or the data.
- R8: When `run` drops, the current four-clock group finishes: the command slot and all three gap clocks are kept. The block then goes idle and outputs deselect.
- R9: During and right after reset the outputs show deselect, with `wvalid`=0, `ba`=0 and `addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to run the stress stream, low to stop after the current group |
| wr_mode | input | 1 | 1 selects writes, 0 selects reads; sampled at run start |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | $clog2(NUM_BANKS) | Bank address |
| addr | output | ADDR_W | Row/column address |
| wdata | output | 2*DQ_W | Two write beats per clock, first beat in the low half |
| wvalid | output | 1 | Write data valid |
| dm | output | 2*DQ_W/8 | Data mask for both beats, always low |

## Verification
A long read run of 131 commands walks the bank counter through many wraps. The column counter wraps past 2^COL_W, which separates a correct modulo step from a saturating or mis-sized counter. During that run `wr_mode` is toggled, which shows whether the mode is really latched at start. A shorter write run follows. It starts again at bank 0 and column 0, and it checks the inverting beat pair, the unbroken valid flag and the WRITE encoding. Each run is stopped in the middle of a group, so the finish-the-group rule can be told apart from an immediate stop or one cycle of overrun.

// File: rtl/bstress_pkg.sv
`timescale 1ns/1ps
package bstress_pkg;

  typedef enum logic [1:0] {
    SL_CMD  = 2'd0,
    SL_GAP1 = 2'd1,
    SL_GAP2 = 2'd2,
    SL_GAP3 = 2'd3
  } slot_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_DESEL = 4'b1111;
  localparam cmd_pins_t PINS_READ  = 4'b0101;
  localparam cmd_pins_t PINS_WRITE = 4'b0100;

  localparam int unsigned BURST_COL_STEP = 8;

  // next bank index with wrap at the bank count
  function automatic int unsigned bank_after(input int unsigned b, input int unsigned nb);
    return (b + 1 >= nb) ? 0 : b + 1;
  endfunction

  // next burst-aligned column, modulo 2^w
  function automatic int unsigned col_after(input int unsigned c, input int unsigned w);
    return (c + BURST_COL_STEP) & ((1 << w) - 1);
  endfunction

  // even beats carry the pattern, odd beats its inverse
  function automatic logic [63:0] beat_word(input logic [63:0] pat, input int unsigned beat);
    return (beat % 2 == 1) ? ~pat : pat;
  endfunction

endpackage

// File: rtl/bstress_seq.sv
`timescale 1ns/1ps
module bstress_seq
  import bstress_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  wr_mode,
  output logic  active,
  output slot_e slot,
  output logic  mode_wr,
  output logic  start,
  output logic  cmd_fire,
  output logic  last_slot
);

  assign start     = run && !active;
  assign cmd_fire  = active && (slot == SL_CMD);
  assign last_slot = active && (slot == SL_GAP3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      slot    <= SL_CMD;
      mode_wr <= 1'b0;
    end else if (!active) begin
      if (run) begin
        active  <= 1'b1;
        slot    <= SL_CMD;
        mode_wr <= wr_mode;
      end
    end else if (slot == SL_GAP3) begin
      slot <= SL_CMD;
      if (!run) active <= 1'b0;
    end else begin
      slot <= slot_e'(slot + 2'd1);
    end
  end

  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire); // R1

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (mode_wr == $past(mode_wr))); // R7

  AST_STOP_AT_GROUP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (last_slot && !run) |=> !active); // R8

  AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_slot) |=> active); // R8

endmodule

// File: rtl/bstress_addr.sv
`timescale 1ns/1ps
module bstress_addr
  import bstress_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned COL_W     = 10,
  localparam int unsigned BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  output logic [BA_W-1:0]  bank,
  output logic [COL_W-1:0] col
);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      bank <= '0;
      col  <= '0;
    end else if (advance) begin
      bank <= BA_W'(bank_after(int'(bank), NUM_BANKS));
      col  <= COL_W'(col_after(int'(col), COL_W));
    end
  end

  AST_BANK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (bank != $past(bank))); // R3

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bank) < NUM_BANKS); // R3

  AST_COL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (col != $past(col))); // R4

  AST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    col[2:0] == 3'b000); // R4

endmodule

// File: rtl/bstress_data.sv
`timescale 1ns/1ps
module bstress_data
  import bstress_pkg::*;
#(
  parameter int unsigned      DQ_W    = 8,
  parameter logic [DQ_W-1:0]  PATTERN = '0,
  localparam int unsigned     BEATS   = 2,
  localparam int unsigned     DM_W    = (DQ_W >= 8) ? (BEATS * DQ_W / 8) : BEATS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  mode_wr,
  input  logic                  last_slot,
  output logic [BEATS*DQ_W-1:0] wdata,
  output logic                  wvalid,
  output logic [DM_W-1:0]       dm
);

  assign wvalid = active && mode_wr;
  assign dm     = '0;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign wdata[b*DQ_W +: DQ_W] =
      wvalid ? DQ_W'(beat_word(64'(PATTERN), b)) : '0;
  end

  AST_WDATA_SEAMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !last_slot) |=> wvalid); // R5

  AST_BEATS_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wdata[DQ_W +: DQ_W] == ~wdata[0 +: DQ_W])); // R5

endmodule

// File: rtl/burst_stress_gen.sv
`timescale 1ns/1ps
module burst_stress_gen
  import bstress_pkg::*;
#(
  parameter int unsigned     NUM_BANKS = 8,
  parameter int unsigned     ADDR_W    = 14,
  parameter int unsigned     COL_W     = 10,
  parameter int unsigned     DQ_W      = 8,
  parameter logic [DQ_W-1:0] PATTERN   = '0,
  localparam int unsigned    BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned    DM_W      = (DQ_W >= 8) ? (2 * DQ_W / 8) : 2,
  localparam int unsigned    AP_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_mode,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [2*DQ_W-1:0] wdata,
  output logic              wvalid,
  output logic [DM_W-1:0]   dm
);

  logic             active, mode_wr, start, cmd_fire, last_slot;
  slot_e            slot;
  logic [BA_W-1:0]  bank;
  logic [COL_W-1:0] col;
  cmd_pins_t        pins;

  bstress_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_mode(wr_mode),
    .active(active), .slot(slot), .mode_wr(mode_wr), .start(start),
    .cmd_fire(cmd_fire), .last_slot(last_slot)
  );

  bstress_addr #(.NUM_BANKS(NUM_BANKS), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(cmd_fire),
    .bank(bank), .col(col)
  );

  bstress_data #(.DQ_W(DQ_W), .PATTERN(PATTERN)) u_data (
    .clk(clk), .rst_n(rst_n), .active(active), .mode_wr(mode_wr),
    .last_slot(last_slot), .wdata(wdata), .wvalid(wvalid), .dm(dm)
  );

  always_comb begin
    pins = PINS_DESEL;
    if (cmd_fire) pins = mode_wr ? PINS_WRITE : PINS_READ;
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign ba = cmd_fire ? bank : '0;

  always_comb begin
    addr = '0;
    if (cmd_fire) addr[COL_W-1:0] = col;
    addr[AP_BIT] = 1'b0;
  end

  AST_WRITE_MATCHES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (wvalid == !we_n)); // R5

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (cs_n && ras_n && cas_n && we_n && !wvalid)); // R2

  AST_ADDR_ZERO_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (addr == '0 && ba == '0)); // R4

endmodule

// File: tb/sim_burst_stress_gen.sv
`timescale 1ns/1ps
module sim_burst_stress_gen;

  localparam int NB   = 8;
  localparam int AW   = 14;
  localparam int CW   = 10;
  localparam int DW   = 8;
  localparam logic [DW-1:0] PAT = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic wr_mode = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, wvalid;
  logic [2:0] ba;
  logic [AW-1:0] addr;
  logic [2*DW-1:0] wdata;
  logic [1:0] dm;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_stress_gen #(.NUM_BANKS(NB), .ADDR_W(AW), .COL_W(CW), .DQ_W(DW), .PATTERN(PAT)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_mode(wr_mode),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .wdata(wdata), .wvalid(wvalid), .dm(dm)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check({cs_n, ras_n, cas_n, we_n} == 4'b1111, req, "idle pins", 32'({cs_n, ras_n, cas_n, we_n}), 32'hF);
    check(wvalid == 1'b0, req, "idle wvalid", 32'(wvalid), 0);
    check(addr == '0 && ba == '0, req, "idle addr/ba", 32'({ba, addr}), 0);
    check(dm == '0, "R6", "dm", 32'(dm), 0);
  endtask

  // expected outputs for clock t of a run, computed arithmetically
  task automatic check_cycle(input int t, input bit wr);
    int n;
    bit is_cmd;
    logic [3:0] exp_pins;
    logic [AW-1:0] exp_addr;
    logic [2:0] exp_ba;
    n = t / 4;
    is_cmd = (t % 4) == 0;
    exp_pins = !is_cmd ? 4'b1111 : (wr ? 4'b0100 : 4'b0101);
    exp_addr = is_cmd ? AW'((n * 8) % (1 << CW)) : '0;
    exp_ba = is_cmd ? 3'(n % NB) : '0;
    check({cs_n, ras_n, cas_n, we_n} == exp_pins, is_cmd ? "R1" : "R2", "pins",
          32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_pins));
    check(ba == exp_ba, "R3", "bank", 32'(ba), 32'(exp_ba));
    check(addr == exp_addr && addr[10] == 1'b0, "R4", "addr", 32'(addr), 32'(exp_addr));
    check(wvalid == wr, "R5", "wvalid", 32'(wvalid), 32'(wr));
    check(wdata == (wr ? {~PAT, PAT} : '0), "R5", "wdata", 32'(wdata),
          32'(wr ? {~PAT, PAT} : 16'h0));
    check(dm == '0, "R6", "dm", 32'(dm), 0);
  endtask

  // ncmd+1 commands issued; run drops in slot 1 of the last group
  task automatic run_phase(input bit wr, input int ncmd, input int flip_t);
    int stop_t;
    stop_t = 4 * ncmd + 1;
    wr_mode = wr;
    run = 1'b1;
    @(negedge clk);
    for (int t = 0; t <= stop_t + 2; t++) begin
      check_cycle(t, wr);
      if (t == flip_t) wr_mode = ~wr; // R7 change ignored
      if (t == stop_t) run = 1'b0;    // R8 group must still finish
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      check_idle("R8");
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R9");
    run_phase(1'b0, 130, 50);  // read, column wrap, mode flip
    run_phase(1'b1, 20, 9);    // write, restart at bank 0
    run_phase(1'b0, 3, 6);     // short read
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule